// File: doc/BRIEF.md
# Burst-of-Two Synchronous SRAM Core

This block is a synthesizable storage core with a shared address for reads and writes, in which every access moves exactly two data beats. A command is accepted on a rising clock edge when the active-low load strobe is low. The same edge captures the pair address and the read/write direction. The double-data-rate beats are modelled in one clock domain as two parallel beat ports. Beat 0 stands for the rising-edge half of the cycle and beat 1 stands for the falling-edge half. Beat 0 always reaches the even word of the addressed pair and beat 1 the odd word.

Each write carries both beats in the load cycle. Each beat has its own active-low lane selects, and a lane that is not selected keeps its stored contents. A read returns both words in the cycle after the load edge, with the valid flag and the output drive-enable raised for that one cycle. A new command can be loaded on every rising edge, so bursts stream with no idle cycles between them.

Top module: `sram_b2_core`

## Requirements
- R1: While reset is asserted and after it is released with no command loaded, `oe_o` and `rvalid_o` are 0 and both read data outputs are all zeros.
- R2: A rising edge with `ld_ni` high starts no access. In the next cycle `rvalid_o` is 0. Write data and selects presented in such a cycle do not change any stored word, and a later read of that word shows this.
- R3: A load with `rw_i` = 1 is a read. In the cycle right after that edge, `rvalid_o` and `oe_o` are both 1, for that one cycle only.
- R4: In a read, `rdata0_o` returns the even word (word index 2*addr) of the pair and `rdata1_o` returns the odd word (2*addr+1).
- R5: A load with `rw_i` = 0 is a write. `wdata0_i` goes to the even word and `wdata1_i` goes to the odd word. In the next cycle `oe_o` and `rvalid_o` stay 0.
- R6: Write select bit k of each beat is active low and guards data bits [k*LW +: LW], where LW = DW/NL. With DW=36 and NL=4, bit 0 covers bits 8:0 and bit 3 covers bits 35:27. A lane whose select is 1 keeps its old contents. The two beats are masked independently.
- R7: A command can be loaded on every consecutive rising edge. Streams of reads, writes and mixes of the two complete with no lost beats.
- R8: A read loaded on the edge right after a write to the same pair returns the newly written data, masked as R6 describes.
- R9: In every cycle in which `rvalid_o` is 0, both read data outputs are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock; commands are taken on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Load strobe, active low |
| rw_i | input | 1 | Direction when loading: 1 read, 0 write |
| addr_i | input | AW | Pair address, AW = clog2(PAIRS) |
| wdata0_i | input | DW | Write data for beat 0 (even word) |
| wdata1_i | input | DW | Write data for beat 1 (odd word) |
| wsel0_ni | input | NL | Active-low lane selects for beat 0 |
| wsel1_ni | input | NL | Active-low lane selects for beat 1 |
| rdata0_o | output | DW | Read data for beat 0 |
| rdata1_o | output | DW | Read data for beat 1 |
| rvalid_o | output | 1 | Read beats valid |
| oe_o | output | 1 | Output drive-enable, high only during read data |

## Verification
On every cycle the assertions check the command-to-output timing. A read load must raise valid and drive-enable on the next cycle, and a write or an idle edge must not. The drive-enable must always track valid, and the data outputs must be zero whenever valid is low. Which words come back, the lane masking on each beat, the write-then-read forwarding and the fact that an unloaded cycle leaves the array untouched all depend on stored contents. Only the bench's reference model can show those, by comparing every cycle of fill, masked-write, idle and mixed streaming scenarios.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/sram_b2_cmd.sv
module sram_b2_cmd
  import sram_b2_pkg::*;
(
  input  logic ld_ni,
  input  logic rw_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (ld_ni)     cmd_o = CMD_IDLE;
    else if (rw_i) cmd_o = CMD_READ;
    else           cmd_o = CMD_WRITE;
  end
endmodule

// File: rtl/sram_b2_lane.sv
// One lane slice of both beat banks: even words (beat 0) and odd words (beat 1).
module sram_b2_lane #(
  parameter int LW    = 9,
  parameter int PAIRS = 256,
  localparam int AW   = $clog2(PAIRS)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we0_i,
  input  logic          we1_i,
  input  logic [LW-1:0] wd0_i,
  input  logic [LW-1:0] wd1_i,
  output logic [LW-1:0] rd0_o,
  output logic [LW-1:0] rd1_o
);
  logic [LW-1:0] even_q [PAIRS];
  logic [LW-1:0] odd_q  [PAIRS];

  always_ff @(posedge clk_i) begin
    if (we0_i) even_q[addr_i] <= wd0_i;
    if (we1_i) odd_q[addr_i]  <= wd1_i;
  end

  assign rd0_o = even_q[addr_i];
  assign rd1_o = odd_q[addr_i];
endmodule

// File: rtl/sram_b2_rd.sv
module sram_b2_rd #(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [DW-1:0] d0_i,
  input  logic [DW-1:0] d1_i,
  output logic [DW-1:0] q0_o,
  output logic [DW-1:0] q1_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q0_o    <= '0;
      q1_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= rd_en_i;
      // idle beats read as zero
      q0_o    <= rd_en_i ? d0_i : '0;
      q1_o    <= rd_en_i ? d1_i : '0;
    end
  end
endmodule

// File: rtl/sram_b2_core.sv
module sram_b2_core
  import sram_b2_pkg::*;
#(
  parameter int DW    = 36,
  parameter int NL    = 4,
  parameter int PAIRS = 256,
  localparam int AW   = $clog2(PAIRS),
  localparam int LW   = DW / NL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata0_i,
  input  logic [DW-1:0] wdata1_i,
  input  logic [NL-1:0] wsel0_ni,
  input  logic [NL-1:0] wsel1_ni,
  output logic [DW-1:0] rdata0_o,
  output logic [DW-1:0] rdata1_o,
  output logic          rvalid_o,
  output logic          oe_o
);
  cmd_e          cmd;
  logic          is_rd, is_wr;
  logic [DW-1:0] arr0, arr1;

  sram_b2_cmd u_cmd (.ld_ni(ld_ni), .rw_i(rw_i), .cmd_o(cmd));

  assign is_rd = (cmd == CMD_READ);
  assign is_wr = (cmd == CMD_WRITE);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    sram_b2_lane #(.LW(LW), .PAIRS(PAIRS)) u_lane (
      .clk_i (clk_i),
      .addr_i(addr_i),
      .we0_i (is_wr & ~wsel0_ni[l]),
      .we1_i (is_wr & ~wsel1_ni[l]),
      .wd0_i (wdata0_i[l*LW +: LW]),
      .wd1_i (wdata1_i[l*LW +: LW]),
      .rd0_o (arr0[l*LW +: LW]),
      .rd1_o (arr1[l*LW +: LW])
    );
  end

  sram_b2_rd #(.DW(DW)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(is_rd),
    .d0_i   (arr0),
    .d1_i   (arr1),
    .q0_o   (rdata0_o),
    .q1_o   (rdata1_o),
    .valid_o(rvalid_o)
  );

  // drive-enable kept in its own flop, next to the pads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_o <= 1'b0;
    else         oe_o <= ~ld_ni & rw_i;
  end
endmodule

// File: rtl/sram_b2_core_chk.sv
module sram_b2_core_chk #(
  parameter int DW = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ld_ni,
  input logic          rw_i,
  input logic [DW-1:0] rdata0_o,
  input logic [DW-1:0] rdata1_o,
  input logic          rvalid_o,
  input logic          oe_o
);
  AST_READ_RAISES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && rw_i) |=> (rvalid_o && oe_o));                               // R3
  AST_NO_LOAD_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> (!rvalid_o && !oe_o));                                        // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && !rw_i) |=> (!oe_o && !rvalid_o));                            // R5
  AST_OE_TRACKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o == rvalid_o);                                                      // R3
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata0_o == '0 && rdata1_o == '0));                      // R9
endmodule

bind sram_b2_core sram_b2_core_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_ni(ld_ni), .rw_i(rw_i),
  .rdata0_o(rdata0_o), .rdata1_o(rdata1_o), .rvalid_o(rvalid_o), .oe_o(oe_o)
);

// File: tb/sram_b2_core_test.sv
`timescale 1ns/1ps
module sram_b2_core_test;
  localparam int DW = 36, NL = 4, PAIRS = 256, AW = 8, LW = DW / NL;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_ni = 1'b1, rw_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata0_i = '0, wdata1_i = '0;
  logic [NL-1:0] wsel0_ni = '1, wsel1_ni = '1;
  logic [DW-1:0] rdata0_o, rdata1_o;
  logic          rvalid_o, oe_o;

  int errors = 0, checks = 0;
  logic [DW-1:0] m0 [PAIRS];
  logic [DW-1:0] m1 [PAIRS];
  logic [DW-1:0] e0, e1;
  logic          ev;

  always #5 clk = ~clk;

  sram_b2_core #(.DW(DW), .NL(NL), .PAIRS(PAIRS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_ni(ld_ni), .rw_i(rw_i), .addr_i(addr_i),
    .wdata0_i(wdata0_i), .wdata1_i(wdata1_i), .wsel0_ni(wsel0_ni), .wsel1_ni(wsel1_ni),
    .rdata0_o(rdata0_o), .rdata1_o(rdata1_o), .rvalid_o(rvalid_o), .oe_o(oe_o)
  );

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (rdata0_o !== e0 || rdata1_o !== e1 || rvalid_o !== ev || oe_o !== ev) begin
      errors++;
      $display("FAIL %s t=%0t actual d0=%h d1=%h v=%b oe=%b expected d0=%h d1=%h v=%b oe=%b",
               tag, $time, rdata0_o, rdata1_o, rvalid_o, oe_o, e0, e1, ev, ev);
    end
  endtask

  // drive at negedge, model the rising edge, compare at the following negedge
  task automatic step(input logic ld, input logic rw, input logic [AW-1:0] a,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [NL-1:0] s0, input logic [NL-1:0] s1, input string tag);
    ld_ni = ~ld; rw_i = rw; addr_i = a;
    wdata0_i = d0; wdata1_i = d1; wsel0_ni = s0; wsel1_ni = s1;
    @(posedge clk);
    if (ld && rw) begin
      e0 = m0[a]; e1 = m1[a]; ev = 1'b1;
    end else begin
      e0 = '0; e1 = '0; ev = 1'b0;
      if (ld) begin
        for (int l = 0; l < NL; l++) begin
          if (!s0[l]) m0[a][l*LW +: LW] = d0[l*LW +: LW];
          if (!s1[l]) m1[a][l*LW +: LW] = d1[l*LW +: LW];
        end
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b1, a, rnd_word(), rnd_word(), 4'($urandom()), 4'($urandom()), tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                    input logic [NL-1:0] s0, input logic [NL-1:0] s1, input string tag);
    step(1'b1, 1'b0, a, d0, d1, s0, s1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    e0 = '0; e1 = '0; ev = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // fill every pair back to back with all lanes selected
    for (int a = 0; a < PAIRS; a++) wr(AW'(a), rnd_word(), rnd_word(), '0, '0, "R5 fill");
    // read stream across edges of the array
    rd(AW'(0), "R4 pair 0");
    rd(AW'(PAIRS-1), "R4 last pair");
    for (int a = 0; a < 16; a++) rd(AW'(a * 7), "R3 R7 read stream");

    // idle edges with junk data must change nothing
    for (int i = 0; i < 6; i++)
      step(1'b0, i[0], AW'(5), rnd_word(), rnd_word(), '0, '0, "R2 idle");
    rd(AW'(5), "R2 readback");

    // independent lane masks per beat
    wr(AW'(9), '1, '0, 4'b1110, 4'b0111, "R6 lane0/lane3");
    rd(AW'(9), "R6 readback a");
    wr(AW'(9), {DW{1'b0}}, '1, 4'b1010, 4'b1111, "R6 lanes1,3 beat1 off");
    rd(AW'(9), "R6 readback b");
    wr(AW'(10), rnd_word(), rnd_word(), '1, '1, "R6 all off");
    rd(AW'(10), "R6 all off readback");

    // write then read same pair on the very next edge
    wr(AW'(33), rnd_word(), rnd_word(), '0, '0, "R8 write");
    rd(AW'(33), "R8 read next");
    wr(AW'(34), rnd_word(), rnd_word(), 4'b0101, 4'b1001, "R8 masked write");
    rd(AW'(34), "R8 masked read next");

    // random mixed stream, idle cycles check R9
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: step(1'b0, 1'b1, a, rnd_word(), rnd_word(), '0, '0, "R9 idle zero");
        1: wr(a, rnd_word(), rnd_word(), 4'($urandom()), 4'($urandom()), "R7 mix write");
        default: rd(a, "R7 mix read");
      endcase
    end
    step(1'b0, 1'b0, '0, '0, '0, '1, '1, "R9 final idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule